// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents one winning request to a processor core as a 3-bit priority level and an 8-bit vector number. Each line has an 8-bit priority byte that also acts as its enable: a line whose byte is zero can never win. Software can hold lines off through a 64-bit mask, and it can raise requests itself through a 64-bit force register.

A line is a candidate when its sampled input or its force bit is set, its priority byte is nonzero, and its mask bit is clear. Among the candidates, the one with the greatest priority byte wins. Equal bytes go to the higher line number. The vector is 64 plus the winning line number. When no line is a candidate, the vector is 24 and the level is 0.

All state is reached through a 32-bit register port with byte offsets. Writes take effect at the clock edge. Read data is a combinational function of the offset. Two single-byte command offsets set or clear one mask bit chosen by number, or the whole mask at once.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the force words read zero, every priority byte reads zero, the level output is 0 and the vector output is 24.
- R2: Each pending bit takes the value of its input line at every clock edge. The pending word at offset 0x00 holds lines 63..32 and the word at 0x04 holds lines 31..0. Writes to either offset change nothing.
- R3: A line is enabled only while its priority byte is nonzero. Writing 0 to the byte withdraws a request that would otherwise win.
- R4: A line is a candidate only when (pending OR forced) AND enabled AND NOT masked.
- R5: The winner is the candidate with the largest priority byte. When two bytes are equal, the higher line number wins.
- R6: The vector output is 64 plus the winner's line number. With no candidate the vector is 24 and the level is 0.
- R7: The level output is the winner's priority byte clamped to 7: bytes 1..7 pass unchanged, and any byte above 7 reports 7.
- R8: A byte write to offset 0x1C with bit 6 set masks all lines. With bit 6 clear, it sets only the mask bit numbered by bits 5:0.
- R9: A byte write to offset 0x1D with bit 6 set unmasks all lines. With bit 6 clear, it clears only the mask bit numbered by bits 5:0.
- R10: The mask words at 0x08 (lines 63..32) and 0x0C (lines 31..0) and the force words at 0x10 (lines 63..32) and 0x14 (lines 31..0) are read/write. The priority byte of line n is at offset 0x40+n, in data bits 7:0.
- R11: A read at offset 0xE0 returns the current vector in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | 8 | Byte offset of the register access |
| wrData | input | 32 | Write data; byte registers use bits 7:0 |
| rdData | output | 32 | Read data for the offset on addr |
| srcLevel | input | 64 | Interrupt request lines, bit n is line n |
| irqLevel | output | 3 | Priority level presented to the core |
| irqVector | output | 8 | Vector number presented to the core |

## Verification
A sweep raises each of the 64 lines alone, with a priority byte that cycles through 1..10. Each step checks the vector, the clamped level, and the drop back to idle when the byte is zeroed. Together these separate vector arithmetic errors from clamp errors and enable errors on every line.

Three lines with deliberately equal and unequal bytes are then raised together. This distinguishes largest-byte selection from lowest-index selection and from tie handling. Single-bit and whole-mask commands, forcing with all inputs low, and ignored writes to the pending words each show up at the vector output and in readback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_CNT  = 64;
  localparam int IDX_W    = $clog2(SRC_CNT);
  localparam int CTL_W    = 8;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int WORD_W   = 32;
  localparam int VEC_BASE = 64;
  localparam int VEC_IDLE = 24;

  typedef enum logic [3:0] {
    RD_NONE, RD_PEND_HI, RD_PEND_LO, RD_MASK_HI, RD_MASK_LO,
    RD_FORCE_HI, RD_FORCE_LO, RD_CTL, RD_VEC
  } rdSel_e;

  typedef struct packed {
    logic              maskHiWr;
    logic              maskLoWr;
    logic              forceHiWr;
    logic              forceLoWr;
    logic              ctlWr;
    logic              maskSet;
    logic              maskClr;
    logic              cmdAll;
    logic [IDX_W-1:0]  ctlIdx;
    logic [IDX_W-1:0]  cmdIdx;
    logic [WORD_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output strobe_t           strb,
  output rdSel_e            rdSel,
  output logic [IDX_W-1:0]  rdIdx
);
  localparam logic [ADDR_W-1:0] OFS_PEND_HI  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_PEND_LO  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_FORCE_HI = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_FORCE_LO = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_SET_CMD  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_CLR_CMD  = ADDR_W'(8'h1D);
  localparam logic [ADDR_W-1:0] OFS_VEC      = ADDR_W'(8'hE0);
  localparam int               CTL_BASE     = 'h40;

  logic inCtlWindow;
  assign inCtlWindow = (int'(addr) >= CTL_BASE) && (int'(addr) < CTL_BASE + SRC_CNT);

  // write strobes
  always_comb begin
    strb           = '0;
    strb.data      = wrData;
    strb.cmdAll    = wrData[6];
    strb.cmdIdx    = wrData[IDX_W-1:0];
    strb.ctlIdx    = addr[IDX_W-1:0];
    if (wrEn) begin
      unique case (addr)
        OFS_MASK_HI:  strb.maskHiWr  = 1'b1;
        OFS_MASK_LO:  strb.maskLoWr  = 1'b1;
        OFS_FORCE_HI: strb.forceHiWr = 1'b1;
        OFS_FORCE_LO: strb.forceLoWr = 1'b1;
        OFS_SET_CMD:  strb.maskSet   = 1'b1;
        OFS_CLR_CMD:  strb.maskClr   = 1'b1;
        default:      strb.ctlWr     = inCtlWindow;
      endcase
    end
  end

  // read select
  always_comb begin
    rdIdx = addr[IDX_W-1:0];
    unique case (addr)
      OFS_PEND_HI:  rdSel = RD_PEND_HI;
      OFS_PEND_LO:  rdSel = RD_PEND_LO;
      OFS_MASK_HI:  rdSel = RD_MASK_HI;
      OFS_MASK_LO:  rdSel = RD_MASK_LO;
      OFS_FORCE_HI: rdSel = RD_FORCE_HI;
      OFS_FORCE_LO: rdSel = RD_FORCE_LO;
      OFS_VEC:      rdSel = RD_VEC;
      default:      rdSel = inCtlWindow ? RD_CTL : RD_NONE;
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  rdSel_e                        rdSel,
  input  logic [IDX_W-1:0]              rdIdx,
  input  logic [SRC_CNT-1:0]            srcLevel,
  input  logic [VEC_W-1:0]              curVector,
  output logic [SRC_CNT-1:0]            pendingQ,
  output logic [SRC_CNT-1:0]            forceQ,
  output logic [SRC_CNT-1:0]            maskQ,
  output logic [SRC_CNT-1:0][CTL_W-1:0] ctlQ,
  output logic [WORD_W-1:0]             rdData
);
  localparam int HALF = SRC_CNT / 2;

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= srcLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceQ <= '0;
    end else begin
      if (strb.forceHiWr) forceQ[SRC_CNT-1:HALF] <= strb.data[HALF-1:0];
      if (strb.forceLoWr) forceQ[HALF-1:0]       <= strb.data[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strb.maskSet) begin
      if (strb.cmdAll) maskQ <= '1;
      else             maskQ[strb.cmdIdx] <= 1'b1;
    end else if (strb.maskClr) begin
      if (strb.cmdAll) maskQ <= '0;
      else             maskQ[strb.cmdIdx] <= 1'b0;
    end else begin
      if (strb.maskHiWr) maskQ[SRC_CNT-1:HALF] <= strb.data[HALF-1:0];
      if (strb.maskLoWr) maskQ[HALF-1:0]       <= strb.data[HALF-1:0];
    end
  end

  generate
    for (genvar g = 0; g < SRC_CNT; g++) begin : g_ctl
      always_ff @(posedge clk) begin
        if (!rstN)                                            ctlQ[g] <= '0;
        else if (strb.ctlWr && strb.ctlIdx == IDX_W'(g))      ctlQ[g] <= strb.data[CTL_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    unique case (rdSel)
      RD_PEND_HI:  rdData = WORD_W'(pendingQ[SRC_CNT-1:HALF]);
      RD_PEND_LO:  rdData = WORD_W'(pendingQ[HALF-1:0]);
      RD_MASK_HI:  rdData = WORD_W'(maskQ[SRC_CNT-1:HALF]);
      RD_MASK_LO:  rdData = WORD_W'(maskQ[HALF-1:0]);
      RD_FORCE_HI: rdData = WORD_W'(forceQ[SRC_CNT-1:HALF]);
      RD_FORCE_LO: rdData = WORD_W'(forceQ[HALF-1:0]);
      RD_CTL:      rdData = WORD_W'(ctlQ[rdIdx]);
      RD_VEC:      rdData = WORD_W'(curVector);
      default:     rdData = '0;
    endcase
  end

  assert_pending_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendingQ == $past(srcLevel)))
    else $error("pending does not follow inputs");
  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskSet && strb.cmdAll) |=> (maskQ == '1))
    else $error("mask-all command ignored");
  assert_unmask_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskClr && strb.cmdAll) |=> (maskQ == '0))
    else $error("unmask-all command ignored");
  assert_force_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.forceHiWr || strb.forceLoWr) |=> $stable(forceQ))
    else $error("force register changed without a write");
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SRC_CNT-1:0]            pendingQ,
  input  logic [SRC_CNT-1:0]            forceQ,
  input  logic [SRC_CNT-1:0]            maskQ,
  input  logic [SRC_CNT-1:0][CTL_W-1:0] ctlQ,
  output logic [LVL_W-1:0]              irqLevel,
  output logic [VEC_W-1:0]              irqVector
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic [SRC_CNT-1:0] activeVec;
  logic [CTL_W-1:0]   bestCtl;
  logic [IDX_W-1:0]   bestIdx;
  logic               anyActive;

  generate
    for (genvar g = 0; g < SRC_CNT; g++) begin : g_act
      assign activeVec[g] = (pendingQ[g] | forceQ[g]) & (|ctlQ[g]) & ~maskQ[g];
    end
  endgenerate

  // ascending scan with >= lets a later equal byte take over: ties go high
  always_comb begin
    bestCtl   = '0;
    bestIdx   = '0;
    anyActive = 1'b0;
    for (int i = 0; i < SRC_CNT; i++) begin
      if (activeVec[i] && ctlQ[i] >= bestCtl) begin
        bestCtl   = ctlQ[i];
        bestIdx   = IDX_W'(i);
        anyActive = 1'b1;
      end
    end
  end

  always_comb begin
    if (!anyActive) begin
      irqLevel  = '0;
      irqVector = VEC_W'(VEC_IDLE);
    end else begin
      irqLevel  = (int'(bestCtl) > LVL_MAX) ? LVL_W'(LVL_MAX) : bestCtl[LVL_W-1:0];
      irqVector = VEC_W'(VEC_BASE) + VEC_W'(bestIdx);
    end
  end

  assert_idle_output_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec == '0) |-> (irqVector == VEC_W'(VEC_IDLE) && irqLevel == '0))
    else $error("idle outputs wrong");
  assert_vector_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec != '0) |-> (irqVector >= VEC_W'(VEC_BASE)))
    else $error("vector below base with a candidate");
  assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec != '0) |-> (irqLevel != '0))
    else $error("candidate with zero level");
  assert_winner_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec != '0) |-> activeVec[irqVector[IDX_W-1:0]])
    else $error("vector names a non-candidate line");
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [63:0]       srcLevel,
  output logic [2:0]        irqLevel,
  output logic [7:0]        irqVector
);
  strobe_t                       strb;
  rdSel_e                        rdSel;
  logic [IDX_W-1:0]              rdIdx;
  logic [SRC_CNT-1:0]            pendingQ;
  logic [SRC_CNT-1:0]            forceQ;
  logic [SRC_CNT-1:0]            maskQ;
  logic [SRC_CNT-1:0][CTL_W-1:0] ctlQ;

  irqc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .rdSel(rdSel), .rdIdx(rdIdx)
  );

  irqc_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .rdIdx(rdIdx),
    .srcLevel(srcLevel), .curVector(irqVector),
    .pendingQ(pendingQ), .forceQ(forceQ), .maskQ(maskQ), .ctlQ(ctlQ),
    .rdData(rdData)
  );

  irqc_arbiter uArb (
    .clk(clk), .rstN(rstN), .pendingQ(pendingQ), .forceQ(forceQ),
    .maskQ(maskQ), .ctlQ(ctlQ), .irqLevel(irqLevel), .irqVector(irqVector)
  );
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] srcLevel = '0;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;

  int total = 0;
  int bad = 0;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcLevel(srcLevel), .irqLevel(irqLevel), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 force hi", d, 32'h0);
    rd(8'h14, d); chk("R1 force lo", d, 32'h0);
    rd(8'h40, d); chk("R1 ctl 0", d, 32'h0);
    rd(8'h7F, d); chk("R1 ctl 63", d, 32'h0);
    chk("R1 level", 32'(irqLevel), 32'd0);
    chk("R1 vector", 32'(irqVector), 32'd24);

    // R9 unmask all
    wr(8'h1D, 32'h40);
    rd(8'h08, d); chk("R9 unmask all hi", d, 32'h0);
    rd(8'h0C, d); chk("R9 unmask all lo", d, 32'h0);

    // R6 R7 R3 sweep over every line
    for (int i = 0; i < 64; i++) begin
      int v;
      v = (i % 10) + 1;
      wr(8'(8'h40 + i), 32'(v));
      srcLevel = 64'd1 << i;
      settle();
      chk("R6 vector sweep", 32'(irqVector), 32'(64 + i));
      chk("R7 level clamp", 32'(irqLevel), 32'((v > 7) ? 7 : v));
      wr(8'(8'h40 + i), 32'h0);
      chk("R3 zero byte disables", 32'(irqVector), 32'd24);
      srcLevel = '0;
      settle();
    end

    // R2 pending readback and ignored writes
    srcLevel = 64'hA5A5_0001_8000_0003;
    settle();
    rd(8'h00, d); chk("R2 pending hi", d, 32'hA5A5_0001);
    rd(8'h04, d); chk("R2 pending lo", d, 32'h8000_0003);
    wr(8'h04, 32'h1234_5678);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R2 pending lo write ignored", d, 32'h8000_0003);
    rd(8'h00, d); chk("R2 pending hi write ignored", d, 32'hA5A5_0001);
    chk("R3 pending but disabled", 32'(irqVector), 32'd24);
    srcLevel = '0;
    settle();

    // R5 priority and tie
    wr(8'h45, 32'd20);
    wr(8'h68, 32'd9);
    wr(8'h7C, 32'd20);
    rd(8'h7C, d); chk("R10 ctl readback", d, 32'd20);
    srcLevel = (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 60);
    settle();
    chk("R5 tie goes to higher line", 32'(irqVector), 32'd124);
    chk("R7 level of 20", 32'(irqLevel), 32'd7);
    rd(8'hE0, d); chk("R11 vector read", d, 32'd124);

    // R8 single set, R4 masked line skipped
    wr(8'h1C, 32'd60);
    rd(8'h08, d); chk("R8 set one mask bit", d, 32'h1000_0000);
    chk("R4 masked line skipped", 32'(irqVector), 32'd69);
    wr(8'h1C, 32'd5);
    chk("R5 lower byte wins when others masked", 32'(irqVector), 32'd104);
    rd(8'h0C, d); chk("R8 set low bit", d, 32'h0000_0020);
    // R9 single clear
    wr(8'h1D, 32'd60);
    chk("R9 clear one mask bit", 32'(irqVector), 32'd124);
    rd(8'h08, d); chk("R9 hi word after clear", d, 32'h0);
    // R8 mask all
    wr(8'h1C, 32'h40);
    rd(8'h08, d); chk("R8 mask all hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R8 mask all lo", d, 32'hFFFF_FFFF);
    chk("R8 all masked idle vector", 32'(irqVector), 32'd24);
    chk("R6 idle level", 32'(irqLevel), 32'd0);
    rd(8'hE0, d); chk("R11 idle vector read", d, 32'd24);

    // R10 mask word writes
    wr(8'h08, 32'hEFFF_FFFF);
    chk("R10 mask hi write unmasks line 60", 32'(irqVector), 32'd124);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R10 mask lo write unmasks line 5", 32'(irqVector), 32'd69);

    // R4 forcing with inputs low
    srcLevel = '0;
    settle();
    chk("R4 nothing pending", 32'(irqVector), 32'd24);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, d); chk("R10 force hi readback", d, 32'h0000_0100);
    chk("R4 forced line 40", 32'(irqVector), 32'd104);
    chk("R7 level 7 passes", 32'(irqLevel), 32'd7);
    wr(8'h14, 32'h0000_0020);
    rd(8'h14, d); chk("R10 force lo readback", d, 32'h0000_0020);
    chk("R5 forced higher byte wins", 32'(irqVector), 32'd69);
    wr(8'h45, 32'd0);
    chk("R3 disabling forced winner", 32'(irqVector), 32'd104);
    wr(8'h10, 32'h0);
    chk("R4 force cleared", 32'(irqVector), 32'd24);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule